// File: doc/BRIEF.md
# Multicycle 32-bit Integer Core

This block is a small 32-bit processor core that runs a subset of a classic load/store integer instruction set: four register-register operations (add unsigned, subtract unsigned, bitwise AND, bitwise OR), an OR with an immediate, a word load, a word store and a branch on equality. Each instruction is spread over several clock cycles. A Moore state machine with fixed 4-bit state codes raises one enable per cycle for the architectural registers: program counter, instruction register, the two operand latches, the equality flag, the ALU result latch and the load latch. Each of these registers changes only while its own enable is high. Instruction classes therefore take different numbers of cycles: 3 for a branch, 4 for register, immediate and store operations, and 5 for a load.

The core holds its own 32-entry register file and two word-addressed memories, one for instructions and one for data. Both are plain arrays that a testbench fills before reset is released. The core has no streaming interface. Its outputs are plain observation pins that are valid while the last state of an instruction is active:
- a retire strobe;
- the program counter of the retiring instruction and the current state code;
- the register write-back about to happen;
- the data store about to happen.

These pins have no handshake and no back-pressure. The core never stalls, and an observer must sample the pins in the cycle the strobe is high.

Top module: `mc_core`

## Requirements
- R1: While reset is low, and in the first cycle after it rises, the state code is 0000 and the program counter is 0. The retire, write-back and store strobes are low.
- R2: Every instruction spends one cycle in fetch (0000) and then one cycle in decode (0001). After the last state of any instruction the next state is fetch.
- R3: Opcode 0x00 is a register operation chosen by bits 5:0. Code 0x21 adds, 0x23 subtracts (rs minus rt), 0x24 ANDs and 0x25 ORs. Any other function code writes zero. The result goes to rd (bits 15:11). The instruction takes 4 cycles and passes through states 0100 and 0101.
- R4: Opcode 0x0D ORs rs with the zero-extended 16-bit immediate and writes the result to rt (bits 20:16). It takes 4 cycles and passes through states 0110 and 0111.
- R5: Opcode 0x23 loads the data word at rs plus the sign-extended immediate into rt. It takes 5 cycles and passes through states 1000, 1001 and 1010. Both memories are indexed by byte address bits above bit 1.
- R6: Opcode 0x2B stores rt to the data word at rs plus the sign-extended immediate. It takes 4 cycles and passes through states 1011 and 1100.
- R7: Opcode 0x04 takes 3 cycles and passes through state 0011. If rs equals rt, the next PC is PC+4 plus the sign-extended immediate shifted left by two. Otherwise the next PC is PC+4.
- R8: Register 0 always reads as zero, and a write to it changes nothing.
- R9: Any other opcode takes 3 cycles and passes through state 0010. It writes no register, stores nothing and advances the PC by 4.
- R10: The retire strobe is high exactly in the last cycle of each instruction. In that cycle the debug PC shows the address of the retiring instruction. A register write is shown on the write-back pins, and a store is shown on the store pins.
- R11: The program counter changes only at the end of an instruction. It advances by 4 except after a taken branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dbg_pc | output | 32 | Current program counter |
| dbg_state | output | 4 | Current controller state code |
| retire | output | 1 | High in the last cycle of each instruction |
| wb_en | output | 1 | Register write happens at the end of this cycle |
| wb_reg | output | 5 | Destination register of that write |
| wb_data | output | 32 | Value written |
| st_en | output | 1 | Data store happens at the end of this cycle |
| st_addr | output | 32 | Byte address of the store |
| st_data | output | 32 | Word stored |

## Verification
The bench releases reset just after a rising edge, so the first fetch cycle is the first cycle it counts. A retire is therefore due 3, 4 or 5 cycles after the previous one, depending on the opcode of the instruction in flight. The bench samples every output on the falling edge. It measures the gap between two retire strobes in those samples and compares it with the expected length. In the same retire cycle it checks the PC, the write-back pins and the store pins against the next queued result of an independent instruction-level model. A wrong branch target or a skipped write shows up at the next retire.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned NREG   = 32;
  localparam int unsigned RIDX_W = $clog2(NREG);

  typedef enum logic [3:0] {
    ST_FETCH   = 4'b0000,
    ST_DECODE  = 4'b0001,
    ST_BAD     = 4'b0010,
    ST_BEQ     = 4'b0011,
    ST_R_EX    = 4'b0100,
    ST_R_WB    = 4'b0101,
    ST_ORI_EX  = 4'b0110,
    ST_ORI_WB  = 4'b0111,
    ST_LW_EX   = 4'b1000,
    ST_LW_MEM  = 4'b1001,
    ST_LW_WB   = 4'b1010,
    ST_SW_EX   = 4'b1011,
    ST_SW_MEM  = 4'b1100
  } state_e;

  localparam logic [5:0] OPC_REG = 6'h00;
  localparam logic [5:0] OPC_ORI = 6'h0D;
  localparam logic [5:0] OPC_LW  = 6'h23;
  localparam logic [5:0] OPC_SW  = 6'h2B;
  localparam logic [5:0] OPC_BEQ = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h21;
  localparam logic [5:0] FN_SUB = 6'h23;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_ZERO
  } alu_op_e;

  typedef enum logic [1:0] {
    OPB_REG, OPB_ZEXT, OPB_SEXT
  } opb_e;

  typedef struct packed {
    logic    ir_en;
    logic    ab_en;
    logic    s_en;
    logic    m_en;
    logic    rf_we;
    logic    wb_from_m;
    logic    dst_rd;
    logic    pc_en;
    logic    pc_br;
    logic    dm_we;
    logic    use_funct;
    alu_op_e alu_op;
    opb_e    opb;
  } ctrl_s;

  function automatic alu_op_e funct_to_op(input logic [5:0] fn);
    case (fn)
      FN_ADD:  return ALU_ADD;
      FN_SUB:  return ALU_SUB;
      FN_AND:  return ALU_AND;
      FN_OR:   return ALU_OR;
      default: return ALU_ZERO;
    endcase
  endfunction
endpackage

// File: rtl/mc_mem.sv
module mc_mem #(
  parameter int unsigned WORDS = 64,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
  import mc_pkg::*;
#(
  parameter int unsigned N  = NREG,
  parameter int unsigned DW = XLEN,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ra,
  input  logic [IW-1:0] rb,
  output logic [DW-1:0] qa,
  output logic [DW-1:0] qb
);
  logic [DW-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs[waddr] <= wdata;
  end

  assign qa = (ra == '0) ? '0 : regs[ra];
  assign qb = (rb == '0) ? '0 : regs[rb];
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int unsigned DW = XLEN
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  output state_e     state,
  output ctrl_s      ctl
);
  state_e state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = ST_FETCH;
    case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OPC_REG: state_d = ST_R_EX;
          OPC_ORI: state_d = ST_ORI_EX;
          OPC_LW:  state_d = ST_LW_EX;
          OPC_SW:  state_d = ST_SW_EX;
          OPC_BEQ: state_d = ST_BEQ;
          default: state_d = ST_BAD;
        endcase
      end
      ST_R_EX:   state_d = ST_R_WB;
      ST_ORI_EX: state_d = ST_ORI_WB;
      ST_LW_EX:  state_d = ST_LW_MEM;
      ST_LW_MEM: state_d = ST_LW_WB;
      ST_SW_EX:  state_d = ST_SW_MEM;
      default:   state_d = ST_FETCH;
    endcase
  end

  // Moore outputs: a function of state_q alone
  always_comb begin
    ctl = '0;
    ctl.alu_op = ALU_ADD;
    ctl.opb    = OPB_REG;
    case (state_q)
      ST_FETCH:  ctl.ir_en = 1'b1;
      ST_DECODE: ctl.ab_en = 1'b1;
      ST_R_EX: begin
        ctl.s_en      = 1'b1;
        ctl.use_funct = 1'b1;
      end
      ST_R_WB: begin
        ctl.rf_we  = 1'b1;
        ctl.dst_rd = 1'b1;
        ctl.pc_en  = 1'b1;
      end
      ST_ORI_EX: begin
        ctl.s_en   = 1'b1;
        ctl.alu_op = ALU_OR;
        ctl.opb    = OPB_ZEXT;
      end
      ST_ORI_WB: begin
        ctl.rf_we = 1'b1;
        ctl.pc_en = 1'b1;
      end
      ST_LW_EX, ST_SW_EX: begin
        ctl.s_en = 1'b1;
        ctl.opb  = OPB_SEXT;
      end
      ST_LW_MEM: ctl.m_en = 1'b1;
      ST_LW_WB: begin
        ctl.rf_we     = 1'b1;
        ctl.wb_from_m = 1'b1;
        ctl.pc_en     = 1'b1;
      end
      ST_SW_MEM: begin
        ctl.dm_we = 1'b1;
        ctl.pc_en = 1'b1;
      end
      ST_BEQ: begin
        ctl.pc_en = 1'b1;
        ctl.pc_br = 1'b1;
      end
      ST_BAD:  ctl.pc_en = 1'b1;
      default: ctl = '0;
    endcase
  end

  assign state = state_q;
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int unsigned IMEM_WORDS = 64,
  parameter int unsigned DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] dbg_pc,
  output logic [3:0]  dbg_state,
  output logic        retire,
  output logic        wb_en,
  output logic [4:0]  wb_reg,
  output logic [31:0] wb_data,
  output logic        st_en,
  output logic [31:0] st_addr,
  output logic [31:0] st_data
);
  localparam int unsigned IAW = $clog2(IMEM_WORDS);
  localparam int unsigned DAW = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, s_q, m_q;
  logic            e_q;
  logic [XLEN-1:0] imem_q, dmem_q, rs_val, rt_val, alu_b, alu_y;
  logic [XLEN-1:0] imm_z, imm_s, pc_inc, br_tgt, wdata;
  logic [RIDX_W-1:0] waddr;
  state_e  state;
  ctrl_s   ctl;
  alu_op_e alu_op;

  wire [5:0]        f_op  = ir_q[31:26];
  wire [RIDX_W-1:0] f_rs  = ir_q[25:21];
  wire [RIDX_W-1:0] f_rt  = ir_q[20:16];
  wire [RIDX_W-1:0] f_rd  = ir_q[15:11];
  wire [5:0]        f_fn  = ir_q[5:0];
  wire [15:0]       f_imm = ir_q[15:0];

  mc_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (f_op),
    .state  (state),
    .ctl    (ctl)
  );

  mc_mem #(.WORDS(IMEM_WORDS), .DW(XLEN)) u_imem (
    .clk   (clk),
    .we    (1'b0),
    .waddr ('0),
    .wdata ('0),
    .raddr (pc_q[IAW+1:2]),
    .rdata (imem_q)
  );

  mc_mem #(.WORDS(DMEM_WORDS), .DW(XLEN)) u_dmem (
    .clk   (clk),
    .we    (ctl.dm_we),
    .waddr (s_q[DAW+1:2]),
    .wdata (b_q),
    .raddr (s_q[DAW+1:2]),
    .rdata (dmem_q)
  );

  mc_regfile #(.N(NREG), .DW(XLEN)) u_rf (
    .clk   (clk),
    .we    (ctl.rf_we),
    .waddr (waddr),
    .wdata (wdata),
    .ra    (f_rs),
    .rb    (f_rt),
    .qa    (rs_val),
    .qb    (rt_val)
  );

  assign imm_z  = {16'b0, f_imm};
  assign imm_s  = {{16{f_imm[15]}}, f_imm};
  assign pc_inc = pc_q + 32'd4;
  assign br_tgt = pc_inc + {imm_s[29:0], 2'b00};

  always_comb begin
    case (ctl.opb)
      OPB_ZEXT: alu_b = imm_z;
      OPB_SEXT: alu_b = imm_s;
      default:  alu_b = b_q;
    endcase
  end

  assign alu_op = ctl.use_funct ? funct_to_op(f_fn) : ctl.alu_op;

  mc_alu #(.DW(XLEN)) u_alu (
    .op (alu_op),
    .a  (a_q),
    .b  (alu_b),
    .y  (alu_y)
  );

  assign waddr = ctl.dst_rd ? f_rd : f_rt;
  assign wdata = ctl.wb_from_m ? m_q : s_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      ir_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
      e_q  <= 1'b0;
      s_q  <= '0;
      m_q  <= '0;
    end else begin
      if (ctl.ir_en) ir_q <= imem_q;
      if (ctl.ab_en) begin
        a_q <= rs_val;
        b_q <= rt_val;
        e_q <= (rs_val == rt_val);
      end
      if (ctl.s_en)  s_q <= alu_y;
      if (ctl.m_en)  m_q <= dmem_q;
      if (ctl.pc_en) pc_q <= (ctl.pc_br && e_q) ? br_tgt : pc_inc;
    end
  end

  assign dbg_pc    = pc_q;
  assign dbg_state = state;
  assign retire    = ctl.pc_en;
  assign wb_en     = ctl.rf_we;
  assign wb_reg    = waddr;
  assign wb_data   = wdata;
  assign st_en     = ctl.dm_we;
  assign st_addr   = s_q;
  assign st_data   = b_q;
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] dbg_pc,
  input logic [3:0]  dbg_state,
  input logic        retire,
  input logic        wb_en,
  input logic        st_en
);
  assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_state == 4'b0000) |=> (dbg_state == 4'b0001));

  assert_back_to_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (dbg_state == 4'b0000));

  assert_pc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |=> $stable(dbg_pc));

  assert_pc_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && dbg_state != 4'b0011) |=> (dbg_pc == $past(dbg_pc) + 32'd4));

  assert_wb_final_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> retire);

  assert_store_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st_en |-> (retire && dbg_state == 4'b1100));

  assert_load_seq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_state == 4'b1001) |=> (dbg_state == 4'b1010));

  assert_bad_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_state == 4'b0010) |-> (!wb_en && !st_en));
endmodule

bind mc_core mc_core_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dbg_pc    (dbg_pc),
  .dbg_state (dbg_state),
  .retire    (retire),
  .wb_en     (wb_en),
  .st_en     (st_en)
);

// File: tb/mc_core_tb_top.sv
`timescale 1ns/1ps
module mc_core_tb_top;
  localparam int NRET = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] dbg_pc, wb_data, st_addr, st_data;
  logic [3:0]  dbg_state;
  logic [4:0]  wb_reg;
  logic        retire, wb_en, st_en;

  always #2.5 clk = ~clk;

  mc_core dut_i (
    .clk(clk), .rst_n(rst_n), .dbg_pc(dbg_pc), .dbg_state(dbg_state),
    .retire(retire), .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data),
    .st_en(st_en), .st_addr(st_addr), .st_data(st_data)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic [5:0]  op;
    logic [3:0]  cycles;
    logic        wb;
    logic [4:0]  wreg;
    logic [31:0] wval;
    logic        st;
    logic [31:0] saddr;
    logic [31:0] sdata;
    logic        r0_case;
  } exp_t;

  exp_t exp_q[$];
  logic [31:0] prog [64];
  logic [31:0] dinit [64];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  bit running = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  function automatic string req_of(input logic [5:0] op);
    case (op)
      6'h00:   return "R3";
      6'h0D:   return "R4";
      6'h23:   return "R5";
      6'h2B:   return "R6";
      6'h04:   return "R7";
      default: return "R9";
    endcase
  endfunction

  // Driver: instruction-level model pushes one expected result per retire
  task automatic build_expect();
    logic [31:0] mr [32];
    logic [31:0] md [64];
    logic [31:0] pc, w, sx, zx, va, vb, ea;
    exp_t it;
    for (int i = 0; i < 32; i++) mr[i] = '0;
    for (int i = 0; i < 64; i++) md[i] = dinit[i];
    pc = '0;
    for (int k = 0; k < NRET; k++) begin
      w  = prog[pc[7:2]];
      sx = {{16{w[15]}}, w[15:0]};
      zx = {16'b0, w[15:0]};
      va = mr[w[25:21]];
      vb = mr[w[20:16]];
      it = '0;
      it.pc = pc;
      it.op = w[31:26];
      ea = va + sx;
      case (w[31:26])
        6'h00: begin
          it.cycles = 4; it.wb = 1; it.wreg = w[15:11];
          case (w[5:0])
            6'h21:   it.wval = va + vb;
            6'h23:   it.wval = va - vb;
            6'h24:   it.wval = va & vb;
            6'h25:   it.wval = va | vb;
            default: it.wval = '0;
          endcase
          pc = pc + 4;
        end
        6'h0D: begin
          it.cycles = 4; it.wb = 1; it.wreg = w[20:16]; it.wval = va | zx;
          pc = pc + 4;
        end
        6'h23: begin
          it.cycles = 5; it.wb = 1; it.wreg = w[20:16]; it.wval = md[ea[7:2]];
          pc = pc + 4;
        end
        6'h2B: begin
          it.cycles = 4; it.st = 1; it.saddr = ea; it.sdata = vb;
          it.r0_case = (w[20:16] == 5'd0);
          md[ea[7:2]] = vb;
          pc = pc + 4;
        end
        6'h04: begin
          it.cycles = 3;
          pc = (va == vb) ? pc + 4 + {sx[29:0], 2'b00} : pc + 4;
        end
        default: begin
          it.cycles = 3;
          pc = pc + 4;
        end
      endcase
      if (it.wb) begin
        it.r0_case = (it.wreg == 5'd0);
        if (it.wreg != 5'd0) mr[it.wreg] = it.wval;
      end
      exp_q.push_back(it);
    end
  endtask

  // Monitor: counts cycles between retires, pops and compares
  int   cyc = 0;
  exp_t cur;
  always @(negedge clk) begin
    if (rst_n && running && !done) begin
      cyc++;
      if (retire) begin
        if (exp_q.size() == 0) begin
          check(0, "R10", "retire with empty queue", 32'd1, 32'd0);
        end else begin
          cur = exp_q.pop_front();
          check(cyc == int'(cur.cycles), (cyc == int'(cur.cycles)) ? "R2" : req_of(cur.op),
                "cycles per instruction", cyc, {28'd0, cur.cycles});
          check(dbg_pc == cur.pc, "R11", "retiring pc", dbg_pc, cur.pc);
          check(wb_en == cur.wb, "R10", "wb_en", {31'd0, wb_en}, {31'd0, cur.wb});
          if (cur.wb) begin
            check(wb_reg == cur.wreg, cur.r0_case ? "R8" : req_of(cur.op), "wb_reg",
                  {27'd0, wb_reg}, {27'd0, cur.wreg});
            check(wb_data == cur.wval, req_of(cur.op), "wb_data", wb_data, cur.wval);
          end
          check(st_en == cur.st, "R10", "st_en", {31'd0, st_en}, {31'd0, cur.st});
          if (cur.st) begin
            check(st_addr == cur.saddr, "R6", "st_addr", st_addr, cur.saddr);
            check(st_data == cur.sdata, cur.r0_case ? "R8" : "R6", "st_data", st_data, cur.sdata);
          end
          if (exp_q.size() == 0) done = 1;
        end
        cyc = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(0, "R10", "watchdog expired", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      prog[i]  = '0;
      dinit[i] = '0;
    end
    dinit[5] = 32'h1234_5678;
    prog[0]  = enc_i(6'h0D, 0, 1, 16'h0005);
    prog[1]  = enc_i(6'h0D, 0, 2, 16'h0003);
    prog[2]  = enc_r(1, 2, 3, 6'h21);
    prog[3]  = enc_r(2, 1, 4, 6'h23);
    prog[4]  = enc_r(1, 2, 5, 6'h24);
    prog[5]  = enc_r(1, 2, 6, 6'h25);
    prog[6]  = enc_i(6'h2B, 0, 3, 16'h0004);
    prog[7]  = enc_i(6'h23, 0, 7, 16'h0004);
    prog[8]  = enc_i(6'h0D, 0, 0, 16'hFFFF);
    prog[9]  = enc_i(6'h2B, 0, 0, 16'h0008);
    prog[10] = enc_i(6'h04, 1, 2, 16'h0005);
    prog[11] = enc_i(6'h04, 3, 7, 16'h0002);
    prog[12] = enc_i(6'h0D, 0, 8, 16'h0001);
    prog[13] = enc_i(6'h0D, 0, 8, 16'h0002);
    prog[14] = 32'hFC00_0000;
    prog[15] = enc_i(6'h0D, 0, 10, 16'h000C);
    prog[16] = enc_i(6'h23, 10, 9, 16'hFFF8);
    prog[17] = enc_i(6'h0D, 1, 11, 16'h8000);
    prog[18] = enc_i(6'h23, 0, 12, 16'h0014);
    prog[19] = enc_r(12, 11, 13, 6'h21);
    prog[20] = enc_r(1, 2, 14, 6'h3F);
    prog[21] = enc_i(6'h2B, 10, 13, 16'h0000);
    prog[22] = enc_i(6'h04, 0, 0, 16'hFFFF);
    for (int i = 0; i < 64; i++) begin
      dut_i.u_imem.mem[i] = prog[i];
      dut_i.u_dmem.mem[i] = dinit[i];
    end
    build_expect();

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(dbg_state == 4'b0000, "R1", "state in reset", {28'd0, dbg_state}, 32'd0);
    check(dbg_pc == 32'd0, "R1", "pc in reset", dbg_pc, 32'd0);
    check(retire == 1'b0, "R1", "retire in reset", {31'd0, retire}, 32'd0);
    check(!wb_en && !st_en, "R1", "strobes in reset", {30'd0, wb_en, st_en}, 32'd0);

    @(posedge clk);
    #1 rst_n = 1'b1;
    running = 1;
    @(negedge clk);
    check(dbg_state == 4'b0000, "R1", "state after release", {28'd0, dbg_state}, 32'd0);
    wait (done);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule